// File: doc/BRIEF.md
# Fractional Pulse-Swallowing Clock Enable

This block turns a fast reference clock into a clock-enable strobe whose average rate is a programmable fraction of the reference. Out of every 32 reference cycles it passes between 1 and 32, so the effective rate is the reference rate scaled by mult/32. The passed cycles are spread as evenly as possible across each 32-cycle frame by a small phase accumulator. Downstream logic in the same clock domain qualifies its flops with the strobe.

Software programs the ratio through a small register port with two words. One word holds a 5-bit ratio code stored in inverted form (mult = 32 − code). The other holds a request flag. Writing the code alone changes nothing on the output. Software then sets the request flag. The hardware adopts the stored code at the next frame boundary and clears the flag one cycle later, so software can poll the flag to learn when the new ratio is live.

Top module: `pswal_top`

## Requirements
- R1: After reset both register words read 0, the active code is 0 and `clk_en` is high on every cycle.
- R2: The ratio code is bits [12:8] of the word at address 0x0E0, and the active multiplier is 32 minus the active code (code 0 gives 32 of 32, code 31 gives 1 of 32).
- R3: Frames are 32 cycles long, and the first frame starts in the first cycle after reset is released. Within a frame, at position p (0..31), with multiplier m, `clk_en` is high exactly when floor((p+1)·m/32) > floor(p·m/32). Each frame therefore holds exactly m enabled cycles.
- R4: The request flag is bit 31 of the word at address 0x004. A write with bit 31 set makes it read 1 from the next cycle on.
- R5: A stored code becomes active only at a frame boundary. If the flag is set in the last cycle of a frame (position 31), the code held in that cycle governs the output from position 0 of the next frame.
- R6: The flag reads 1 through the first cycle of the new frame and reads 0 from the second cycle on, unless that same cycle writes bit 31 as 1.
- R7: A write of 0 to bit 31 of the flag word leaves the flag unchanged.
- R8: All other bits of both words are plain read/write storage that reads back what was written.
- R9: Changing the code field without setting the flag leaves the output pattern unchanged.
- R10: Reads of any other address return 0, and writes to them change no state that can be read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 12 | Register byte address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| clk_en | output | 1 | Clock-enable strobe for the current cycle |

## Verification
On every cycle, the embedded assertions check that the frame counter wraps, that the accumulator returns to zero at each frame start, how the request flag sets, holds and clears, and that the active code changes only after a frame-end cycle in which the flag was set. The bench's reference model predicts the exact enable pattern from the spreading formula, including the per-frame pulse count. It also predicts the one-frame latency of adoption, the flag timing seen through polling, and how register storage behaves for writes of 0 to the flag and writes to unmapped addresses. Those properties can only be shown by running scenarios.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_FREQ = 2'd1,
      SEL_KICK = 2'd2
   } reg_sel_e;

   localparam int unsigned PSWAL_DATA_W = 32;

endpackage

// File: rtl/pswal_regs.sv
module pswal_regs #(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CODE_W   = 5,
   parameter int unsigned CODE_LSB = 8,
   parameter int unsigned KICK_BIT = 31,
   parameter logic [ADDR_W-1:0] FREQ_ADDR = 12'h0E0,
   parameter logic [ADDR_W-1:0] KICK_ADDR = 12'h004
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              clear_kick,
   output logic [CODE_W-1:0] code,
   output logic              kick
);
   import pswal_pkg::*;

   localparam logic [DATA_W-1:0] KMASK = DATA_W'(1) << KICK_BIT;

   generate
      if (CODE_LSB + CODE_W > DATA_W) begin : g_bad_field
         $error("pswal_regs: code field exceeds data width");
      end
      if (KICK_BIT >= DATA_W) begin : g_bad_kick
         $error("pswal_regs: request bit outside data width");
      end
      if (FREQ_ADDR == KICK_ADDR) begin : g_bad_map
         $error("pswal_regs: register addresses collide");
      end
   endgenerate

   reg_sel_e          sel;
   logic [DATA_W-1:0] freq_q;
   logic [DATA_W-1:0] kick_q;
   logic [DATA_W-1:0] kick_d;
   logic              set_req;

   always_comb begin
      if (addr == FREQ_ADDR)      sel = SEL_FREQ;
      else if (addr == KICK_ADDR) sel = SEL_KICK;
      else                        sel = SEL_NONE;
   end

   assign set_req = wr && (sel == SEL_KICK) && wdata[KICK_BIT];

   always_comb begin
      kick_d = kick_q;
      if (wr && (sel == SEL_KICK)) begin
         // request bit can only be raised by software; other bits are storage
         kick_d = (wdata & ~KMASK) | (kick_q & KMASK) | (wdata & KMASK);
      end
      if (clear_kick && !set_req) begin
         kick_d[KICK_BIT] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         freq_q <= '0;
         kick_q <= '0;
      end else begin
         if (wr && (sel == SEL_FREQ)) freq_q <= wdata;
         kick_q <= kick_d;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_FREQ: rdata = freq_q;
         SEL_KICK: rdata = kick_q;
         default:  rdata = '0;
      endcase
   end

   assign code = freq_q[CODE_LSB +: CODE_W];
   assign kick = kick_q[KICK_BIT];

   // R4: a write of 1 raises the flag on the next cycle
   p_kick_set_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> kick_q[KICK_BIT]);

   // R6: completion drops the flag unless a new request arrives
   p_kick_clear_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (clear_kick && !set_req) |=> !kick_q[KICK_BIT]);

   // R7: nothing but completion lowers the flag
   p_kick_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (kick_q[KICK_BIT] && !clear_kick) |=> kick_q[KICK_BIT]);

endmodule

// File: rtl/pswal_frame.sv
module pswal_frame #(
   parameter int unsigned CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [CODE_W-1:0] pos,
   output logic              frame_last
);
   localparam logic [CODE_W-1:0] LAST = '1;

   generate
      if (CODE_W < 2 || CODE_W > 12) begin : g_bad_w
         $error("pswal_frame: unsupported frame width");
      end
   endgenerate

   logic [CODE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign pos        = cnt_q;
   assign frame_last = (cnt_q == LAST);

   // R3: the frame wraps to position 0 after its last cycle
   p_frame_wrap_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_last |=> (cnt_q == '0));

endmodule

// File: rtl/pswal_accum.sv
module pswal_accum #(
   parameter int unsigned CODE_W  = 5,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CODE_W:0] mult,
   input  logic            frame_last,
   output logic            en
);
   logic [CODE_W-1:0] acc_q;
   logic [CODE_W:0]   sum;
   logic              carry;

   assign sum   = {1'b0, acc_q} + mult;
   assign carry = sum[CODE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= sum[CODE_W-1:0];
   end

   generate
      if (OUT_REG) begin : g_out_reg
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= carry;
         end
         assign en = en_q;
      end else begin : g_out_comb
         assign en = carry;
      end
   endgenerate

   // R3: a whole frame adds m*32, so phase returns to zero at each frame start
   p_acc_zero_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_last |=> (acc_q == '0));

endmodule

// File: rtl/pswal_top.sv
module pswal_top #(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned CODE_W   = 5,
   parameter int unsigned CODE_LSB = 8,
   parameter int unsigned KICK_BIT = 31,
   parameter logic [ADDR_W-1:0] FREQ_ADDR = 12'h0E0,
   parameter logic [ADDR_W-1:0] KICK_ADDR = 12'h004,
   parameter bit          OUT_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              clk_en
);
   import pswal_pkg::*;

   localparam int unsigned DATA_W = PSWAL_DATA_W;
   localparam logic [CODE_W:0] FULL = (CODE_W+1)'(1) << CODE_W;

   logic [CODE_W-1:0] code;
   logic              kick;
   logic [CODE_W-1:0] pos;
   logic              frame_last;
   logic [CODE_W-1:0] act_code_q;
   logic              adopt;
   logic              adopt_q;
   logic [CODE_W:0]   mult;

   pswal_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
      .CODE_LSB(CODE_LSB), .KICK_BIT(KICK_BIT),
      .FREQ_ADDR(FREQ_ADDR), .KICK_ADDR(KICK_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .clear_kick(adopt_q),
      .code(code), .kick(kick)
   );

   pswal_frame #(.CODE_W(CODE_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .pos(pos), .frame_last(frame_last)
   );

   assign adopt = frame_last && kick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_code_q <= '0;
         adopt_q    <= 1'b0;
      end else begin
         if (adopt) act_code_q <= code;
         adopt_q <= adopt;
      end
   end

   assign mult = FULL - {1'b0, act_code_q};

   pswal_accum #(.CODE_W(CODE_W), .OUT_REG(OUT_REG)) u_accum (
      .clk(clk), .rst_n(rst_n), .mult(mult), .frame_last(frame_last), .en(clk_en)
   );

   // R5: the active code moves only after a frame-end cycle
   p_adopt_boundary_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (act_code_q != $past(act_code_q)) |-> ($past(pos) == '1));

   // R9: the active code moves only when a request was pending
   p_needs_request_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (act_code_q != $past(act_code_q)) |-> $past(kick));

   // R6: the flag is still visible in the first cycle of the new frame
   p_flag_visible_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      adopt |=> kick);

endmodule

// File: tb/tb_pswal_top.sv
module tb_pswal_top;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG       = 20000;
   localparam logic [11:0] A_FREQ = 12'h0E0;
   localparam logic [11:0] A_KICK = 12'h004;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        clk_en;

   pswal_top dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en(clk_en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int tests = 0;
   int fails = 0;

   // behavioural model state
   logic [31:0] m_freq = '0;
   logic [31:0] m_kick = '0;
   int          m_act  = 0;
   bit          m_done = 1'b0;
   int          m_pos  = 0;
   int          m_cnt  = 0;
   string       tag_en = "R1";
   string       tag_rd = "R1";

   function automatic logic [31:0] m_read(logic [11:0] a);
      if (a == A_FREQ) return m_freq;
      if (a == A_KICK) return m_kick;
      return 32'h0;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h (frame pos %0d)", tag, act, exp, m_pos);
      end
   endtask

   // one clock: drive at negedge, compare, advance model at posedge
   task automatic step(bit wr, logic [11:0] a, logic [31:0] d);
      int  m;
      bit  e;
      bit  adopt;
      reg_wr = wr; reg_addr = a; reg_wdata = d;
      #1;
      m = 32 - m_act;
      e = (((m_pos + 1) * m) / 32) > ((m_pos * m) / 32);
      check(tag_en, {31'b0, clk_en}, {31'b0, e});
      check(tag_rd, reg_rdata, m_read(a));
      m_cnt += int'(clk_en);
      if (m_pos == 31) begin
         check({tag_en, " count R3"}, m_cnt, m);
         m_cnt = 0;
      end
      @(posedge clk);
      adopt = (m_pos == 31) && m_kick[31];
      if (adopt) m_act = int'(m_freq[12:8]);
      if (wr && a == A_FREQ) m_freq = d;
      if (wr && a == A_KICK) m_kick = {m_kick[31] | d[31], d[30:0]};
      if (m_done && !(wr && a == A_KICK && d[31])) m_kick[31] = 1'b0;
      m_done = adopt;
      m_pos = (m_pos + 1) % 32;
      @(negedge clk);
   endtask

   task automatic idle(int n, logic [11:0] a);
      for (int i = 0; i < n; i++) step(1'b0, a, 32'h0);
   endtask

   task automatic program_code(int c);
      int guard;
      step(1'b1, A_FREQ, 32'(c) << 8);
      step(1'b1, A_KICK, 32'h8000_0000);
      guard = 0;
      while (reg_rdata[31] && guard < 100) begin
         step(1'b0, A_KICK, 32'h0);
         guard++;
      end
      tag_rd = "R6 poll";
      check(tag_rd, {31'b0, reg_rdata[31]}, 32'h0);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, full rate
      tag_en = "R1"; tag_rd = "R1";
      idle(8, A_FREQ);
      idle(8, A_KICK);
      idle(20, A_FREQ);

      // R9 / R2 / R8: code stored, no request, no effect
      tag_en = "R9"; tag_rd = "R2 R8";
      step(1'b1, A_FREQ, 32'hA5A5_1F5A);
      idle(70, A_FREQ);

      // R4 / R5 / R6: request mid-frame, adopted at the boundary
      tag_en = "R5"; tag_rd = "R4 R6";
      idle(7, A_KICK);
      step(1'b1, A_KICK, 32'h8000_0000);
      idle(40, A_KICK);
      tag_en = "R3 m1"; tag_rd = "R2";
      idle(64, A_FREQ);

      // R7 / R8: zero write to the flag while pending keeps it set
      tag_en = "R7"; tag_rd = "R7 R8";
      step(1'b1, A_FREQ, 32'h0000_0500);
      step(1'b1, A_KICK, 32'h8000_0000);
      step(1'b1, A_KICK, 32'h1234_5678);
      idle(3, A_KICK);
      step(1'b1, A_KICK, 32'h0000_00FF);
      idle(40, A_KICK);

      // R3 across several ratios
      tag_en = "R3 m27"; tag_rd = "R3";
      idle(64, A_FREQ);
      program_code(16); tag_en = "R3 m16"; idle(64, A_FREQ);
      program_code(20); tag_en = "R3 m12"; idle(64, A_FREQ);
      program_code(3);  tag_en = "R3 m29"; idle(64, A_FREQ);
      program_code(31); tag_en = "R3 m1b"; idle(64, A_FREQ);

      // R6: request re-set in the very clearing cycle survives
      tag_en = "R6"; tag_rd = "R6";
      step(1'b1, A_FREQ, 32'h0000_0A00);
      while (m_pos != 30) step(1'b0, A_KICK, 32'h0);
      step(1'b1, A_KICK, 32'h8000_0000);
      step(1'b0, A_KICK, 32'h0);
      step(1'b1, A_KICK, 32'h8000_0000);
      idle(70, A_KICK);

      // R10: unmapped addresses
      tag_en = "R10"; tag_rd = "R10";
      step(1'b1, 12'h100, 32'hFFFF_FFFF);
      idle(4, 12'h100);
      idle(4, 12'h008);
      idle(4, A_FREQ);
      idle(4, A_KICK);

      // R2 / R1: back to full rate
      program_code(0);
      tag_en = "R2 full"; tag_rd = "R2";
      idle(40, A_FREQ);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule